// File: doc/BRIEF.md
# Dual-Half Serial LCD Line Capture Receiver

This block sits where the glass of a passive monochrome panel would be. It listens to the refresh stream a panel controller sends and rebuilds the picture line by line. The stream has five signals: a column shift clock, a line latch strobe, a first-line marker and two serial pixel lines. One pixel line feeds the upper half of the screen and the other feeds the lower half. Both halves fill at the same time, so one line period yields one row of each half. With the default parameters this is a 240-column by 128-row panel, seen as two 240x64 halves stacked one above the other.

All five inputs are asynchronous to the system clock. Each is synchronised, and the two strobes are edge-detected. Pixels shift into one column register per half. Each column register is a chain of equal-length stages. The row is not decoded from counters. A single-bit token is loaded by the first-line marker, and each line latch moves it down one place. The token's position gives the row index that goes out with each captured pair of lines. Two sticky flags report a wrong number of column clocks between latches and a latch that arrives with no token left.

Top module: `lcd_scan_capture`

## Requirements
- R1: After reset, line_valid_o and frame_start_o are low, row_o is 0, both line outputs are all zeros, and length_error_o and sync_error_o are low.
- R2: The data_hi_i level present at a rising edge of col_clk_i is sampled. The k-th bit sampled after a line latch (k counted from 0) appears at upper_line_o[k] when that line is written out.
- R3: data_lo_i is sampled on the same col_clk_i edges as data_hi_i and lands in lower_line_o with the same bit order, independently of the upper half.
- R4: Each rising edge of line_latch_i that finds a row token produces exactly one single-cycle pulse on line_valid_o. The pulse comes a fixed few system cycles after the edge and carries the row index and both captured lines.
- R5: A latch edge where first_line_i is 1 writes row 0. Each later latch edge where first_line_i is 0 writes the next row (1, 2, ...). The row index is the position of the single 1 in the row token.
- R6: frame_start_o pulses for one cycle, together with line_valid_o and row_o = 0, at every latch edge where first_line_i is 1, and at no other time.
- R7: If the number of col_clk_i rising edges since the previous latch (or since reset) is not the column count (240 by default), length_error_o goes high at that latch and stays high until reset. The line is still written out.
- R8: A latch edge with first_line_i at 0 and no token left (after the last row of a frame) raises sync_error_o, which stays high until reset, and produces no line_valid_o pulse.
- R9: The first-line marker reloads the token to row 0 even in the middle of a frame, so the token never holds more than one 1.
- R10: With the system clock at eight times the column clock rate (the 2.5 MHz maximum), every pixel is captured correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_clk_i | input | 1 | Column shift clock (asynchronous) |
| line_latch_i | input | 1 | Line latch strobe (asynchronous) |
| first_line_i | input | 1 | First-line marker, sampled at the latch edge |
| data_hi_i | input | 1 | Serial pixel data for the upper half |
| data_lo_i | input | 1 | Serial pixel data for the lower half |
| line_valid_o | output | 1 | One-cycle pulse: a captured line pair is on the outputs |
| row_o | output | $clog2(HALF_ROWS) | Row index within each half |
| upper_line_o | output | COLS | Captured upper-half line, bit k = column k |
| lower_line_o | output | COLS | Captured lower-half line, bit k = column k |
| frame_start_o | output | 1 | One-cycle pulse when the first-line marker is captured |
| length_error_o | output | 1 | Sticky: wrong number of column clocks in a line |
| sync_error_o | output | 1 | Sticky: latch arrived with no row token |

## Verification
The bench runs every row of a reduced configuration (three 8-column stages, 8 rows per half) through four pixel patterns, each chosen to expose a different fault:
- Opposite constant levels on the two halves show whether the halves are swapped or cross-coupled.
- A walking single pixel whose column tracks the row, mirrored in the lower half, exposes errors in bit order, stage linking and row stepping.
- A column-parity pattern inverted between halves catches an off-by-one shift.
- An arithmetic mix catches anything else.

Separate sequences restart the frame part-way through, latch past the last row, and send lines one column short and one column long, to show the re-sync rule and both sticky flags.

// File: rtl/lcd_cap_pkg.sv
package lcd_cap_pkg;

  localparam int unsigned SCAN_MAXW = 1024;

  typedef struct packed {
    logic dlo;
    logic dhi;
    logic mark;
    logic lat;
    logic col;
  } pins_t;

  localparam int unsigned PINS_W = $bits(pins_t);

  // Position of the lowest set bit among the first n bits of v (0 if none).
  function automatic int unsigned lowest_set(input logic [SCAN_MAXW-1:0] v,
                                             input int unsigned n);
    int unsigned idx;
    idx = 0;
    for (int unsigned i = n; i > 0; i--) begin
      if (v[i-1]) idx = i - 1;
    end
    return idx;
  endfunction

  // Line length is good only when exactly cols shifts were seen.
  function automatic logic length_ok(input int unsigned seen, input int unsigned cols);
    return seen == cols;
  endfunction

  // Saturating count of column shifts, capped at cols+1.
  function automatic int unsigned count_step(input int unsigned seen, input int unsigned cols);
    return (seen > cols) ? seen : seen + 1;
  endfunction

endpackage

// File: rtl/lcd_cap_sync.sv
module lcd_cap_sync #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/lcd_cap_colshift.sv
module lcd_cap_colshift #(
  parameter int STAGE_COLS = 80,
  parameter int NUM_STAGES = 3,
  localparam int COLS = STAGE_COLS * NUM_STAGES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            din,
  output logic [COLS-1:0] q
);
  logic [STAGE_COLS-1:0] st   [NUM_STAGES];
  logic                  feed [NUM_STAGES];

  // The serial input enters the top stage; each stage feeds the one below.
  // After COLS shifts the first bit sits in q[0].
  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    if (s == NUM_STAGES - 1) begin : g_head
      assign feed[s] = din;
    end else begin : g_link
      assign feed[s] = st[s+1][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st[s] <= '0;
      else if (shift_en) st[s] <= {feed[s], st[s][STAGE_COLS-1:1]};
    end

    assign q[s*STAGE_COLS +: STAGE_COLS] = st[s];
  end
endmodule

// File: rtl/lcd_cap_rowtok.sv
module lcd_cap_rowtok
  import lcd_cap_pkg::*;
#(
  parameter int ROWS = 64,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            mark,
  output logic [ROWS-1:0] tok_q,
  output logic [ROWS-1:0] tok_next,
  output logic            tok_next_empty,
  output logic [RW-1:0]   row_next
);
  localparam logic [ROWS-1:0] TOK_ROW0 = {{(ROWS-1){1'b0}}, 1'b1};

  // The marker reloads a single token at row 0; otherwise the token moves down one row.
  assign tok_next       = mark ? TOK_ROW0 : (tok_q << 1);
  assign tok_next_empty = (tok_next == '0);
  assign row_next       = RW'(lowest_set(SCAN_MAXW'(tok_next), ROWS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tok_q <= '0;
    else if (adv) tok_q <= tok_next;
  end
endmodule

// File: rtl/lcd_scan_capture.sv
module lcd_scan_capture
  import lcd_cap_pkg::*;
#(
  parameter int STAGE_COLS = 80,
  parameter int NUM_STAGES = 3,
  parameter int HALF_ROWS  = 64,
  parameter int SYNC_DEPTH = 2,
  localparam int COLS = STAGE_COLS * NUM_STAGES,
  localparam int RW   = (HALF_ROWS > 1) ? $clog2(HALF_ROWS) : 1,
  localparam int CW   = $clog2(COLS + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            col_clk_i,
  input  logic            line_latch_i,
  input  logic            first_line_i,
  input  logic            data_hi_i,
  input  logic            data_lo_i,
  output logic            line_valid_o,
  output logic [RW-1:0]   row_o,
  output logic [COLS-1:0] upper_line_o,
  output logic [COLS-1:0] lower_line_o,
  output logic            frame_start_o,
  output logic            length_error_o,
  output logic            sync_error_o
);
  // Input synchronisation
  logic [PINS_W-1:0] pins_raw;
  logic [PINS_W-1:0] pins_sync;
  pins_t             pin;

  assign pins_raw = {data_lo_i, data_hi_i, first_line_i, line_latch_i, col_clk_i};

  lcd_cap_sync #(.W(PINS_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_sync)
  );
  assign pin = pins_t'(pins_sync);

  // Rising-edge events on the two strobes
  logic col_prev, lat_prev;
  logic col_evt, lat_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_prev <= 1'b0;
      lat_prev <= 1'b0;
    end else begin
      col_prev <= pin.col;
      lat_prev <= pin.lat;
    end
  end

  assign col_evt = pin.col & ~col_prev;
  assign lat_evt = pin.lat & ~lat_prev;

  // Column registers, one per half
  logic [COLS-1:0] hi_q, lo_q;

  lcd_cap_colshift #(.STAGE_COLS(STAGE_COLS), .NUM_STAGES(NUM_STAGES)) u_col_hi (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(col_evt),
    .din     (pin.dhi),
    .q       (hi_q)
  );

  lcd_cap_colshift #(.STAGE_COLS(STAGE_COLS), .NUM_STAGES(NUM_STAGES)) u_col_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(col_evt),
    .din     (pin.dlo),
    .q       (lo_q)
  );

  // Row token
  logic [HALF_ROWS-1:0] tok_q, tok_next;
  logic                 tok_next_empty;
  logic [RW-1:0]        row_next;

  lcd_cap_rowtok #(.ROWS(HALF_ROWS)) u_rowtok (
    .clk           (clk),
    .rst_n         (rst_n),
    .adv           (lat_evt),
    .mark          (pin.mark),
    .tok_q         (tok_q),
    .tok_next      (tok_next),
    .tok_next_empty(tok_next_empty),
    .row_next      (row_next)
  );

  // Column-shift count per line
  logic [CW-1:0] col_cnt;
  logic          len_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       col_cnt <= '0;
    else if (lat_evt) col_cnt <= '0;
    else if (col_evt) col_cnt <= CW'(count_step(int'(col_cnt), COLS));
  end

  assign len_bad = lat_evt & ~length_ok(int'(col_cnt), COLS);

  // Line write port and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_valid_o   <= 1'b0;
      frame_start_o  <= 1'b0;
      row_o          <= '0;
      upper_line_o   <= '0;
      lower_line_o   <= '0;
      length_error_o <= 1'b0;
      sync_error_o   <= 1'b0;
    end else begin
      line_valid_o  <= 1'b0;
      frame_start_o <= 1'b0;
      if (len_bad) length_error_o <= 1'b1;
      if (lat_evt) begin
        if (tok_next_empty) begin
          sync_error_o <= 1'b1;
        end else begin
          line_valid_o  <= 1'b1;
          frame_start_o <= pin.mark;
          row_o         <= row_next;
          upper_line_o  <= hi_q;
          lower_line_o  <= lo_q;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_scan_capture_chk.sv
module lcd_scan_capture_chk #(
  parameter int ROWS = 64,
  parameter int RW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lat_evt,
  input logic [ROWS-1:0] tok_q,
  input logic [ROWS-1:0] tok_next,
  input logic            line_valid,
  input logic            frame_start,
  input logic [RW-1:0]   row,
  input logic            length_error,
  input logic            sync_error
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> !line_valid); // R4

  AST_VALID_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> $past(lat_evt)); // R4

  AST_FRAME_AT_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_valid && row == '0)); // R6

  AST_NO_TOKEN_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_evt && tok_next == '0) |=> (!line_valid && sync_error)); // R8

  AST_TOKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok_q)); // R9

  AST_LEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    length_error |=> length_error); // R7

  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_error |=> sync_error); // R8
endmodule

bind lcd_scan_capture lcd_scan_capture_chk #(.ROWS(HALF_ROWS), .RW(RW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lat_evt     (lat_evt),
  .tok_q       (tok_q),
  .tok_next    (tok_next),
  .line_valid  (line_valid_o),
  .frame_start (frame_start_o),
  .row         (row_o),
  .length_error(length_error_o),
  .sync_error  (sync_error_o)
);

// File: tb/sim_lcd_scan_capture.sv
module sim_lcd_scan_capture;
  localparam int CLK_PERIOD = 10;
  localparam int SC   = 8;
  localparam int ST   = 3;
  localparam int N    = SC * ST;
  localparam int ROWS = 8;
  localparam int RW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic col_clk = 1'b0, latch = 1'b0, mark = 1'b0, dhi = 1'b0, dlo = 1'b0;
  logic          line_valid, frame_start, len_err, sync_err;
  logic [RW-1:0] row;
  logic [N-1:0]  up_line, lo_line;

  int total = 0;
  int failed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_capture #(.STAGE_COLS(SC), .NUM_STAGES(ST), .HALF_ROWS(ROWS)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .col_clk_i     (col_clk),
    .line_latch_i  (latch),
    .first_line_i  (mark),
    .data_hi_i     (dhi),
    .data_lo_i     (dlo),
    .line_valid_o  (line_valid),
    .row_o         (row),
    .upper_line_o  (up_line),
    .lower_line_o  (lo_line),
    .frame_start_o (frame_start),
    .length_error_o(len_err),
    .sync_error_o  (sync_err)
  );

  // Monitor, sampled away from the active edge
  int            n_valid = 0;
  int            n_fs = 0;
  logic [RW-1:0] cap_row = '0;
  logic [N-1:0]  cap_hi = '0, cap_lo = '0;

  always @(negedge clk) begin
    if (line_valid) begin
      n_valid++;
      cap_row = row;
      cap_hi  = up_line;
      cap_lo  = lo_line;
    end
    if (frame_start) n_fs++;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pixel value: half 0 = upper, 1 = lower
  function automatic logic pix(input int half, input int r, input int c, input int pat);
    case (pat)
      0:       return half == 0;
      1:       return (half == 0) ? (c == r * 3) : (c == N - 1 - r * 3);
      2:       return ((c % 2) ^ half) != 0;
      default: return ((c * 3 + r * 5 + half * 2 + 1) % 7) < 3;
    endcase
  endfunction

  function automatic logic [N-1:0] exp_line(input int half, input int r, input int pat);
    logic [N-1:0] v;
    for (int c = 0; c < N; c++) v[c] = pix(half, r, c, pat);
    return v;
  endfunction

  // One column clock period is 8 system cycles (system clock 8x column clock)
  task automatic send_line(input int r, input int pat, input int ncols);
    for (int c = 0; c < ncols; c++) begin
      dhi = pix(0, r, c % N, pat);
      dlo = pix(1, r, c % N, pat);
      wait_cyc(2);
      col_clk = 1'b1;
      wait_cyc(4);
      col_clk = 1'b0;
      wait_cyc(2);
    end
  endtask

  int dv, dfs;
  task automatic do_latch(input logic m);
    int v0, f0;
    v0 = n_valid;
    f0 = n_fs;
    mark = m;
    wait_cyc(2);
    latch = 1'b1;
    wait_cyc(4);
    latch = 1'b0;
    wait_cyc(4);
    mark = 1'b0;
    wait_cyc(4);
    dv  = n_valid - v0;
    dfs = n_fs - f0;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic check_reset_state();
    check(line_valid == 1'b0, "R1 line_valid", 64'(line_valid), 0);
    check(frame_start == 1'b0, "R1 frame_start", 64'(frame_start), 0);
    check(row == '0, "R1 row", 64'(row), 0);
    check(up_line == '0 && lo_line == '0, "R1 lines", 64'(up_line | lo_line), 0);
    check(len_err == 1'b0 && sync_err == 1'b0, "R1 errors", 64'({len_err, sync_err}), 0);
  endtask

  task automatic line_and_check(input int r, input int pat, input logic m);
    logic [N-1:0] eh, el;
    send_line(r, pat, N);
    do_latch(m);
    eh = exp_line(0, r, pat);
    el = exp_line(1, r, pat);
    check(dv == 1, "R4 one valid pulse", 64'(dv), 1);
    check(cap_row == RW'(r), "R5 row index", 64'(cap_row), 64'(r));
    check(cap_hi == eh, "R2 R10 upper line", 64'(cap_hi), 64'(eh));
    check(cap_lo == el, "R3 lower line", 64'(cap_lo), 64'(el));
    check(dfs == ((r == 0) ? 1 : 0), "R6 frame_start", 64'(dfs), 64'((r == 0) ? 1 : 0));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failed++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin : main
    wait_cyc(3);
    check_reset_state();
    rst_n = 1'b1;
    wait_cyc(2);

    // Full frames under each pixel pattern
    for (int pat = 0; pat < 4; pat++) begin
      for (int r = 0; r < ROWS; r++) line_and_check(r, pat, (r == 0));
    end
    check(len_err == 1'b0, "R7 no length error on good lines", 64'(len_err), 0);
    check(sync_err == 1'b0, "R8 no sync error within frames", 64'(sync_err), 0);

    // Marker part-way through a frame restarts at row 0
    for (int r = 0; r < 3; r++) line_and_check(r, 3, (r == 0));
    line_and_check(0, 2, 1'b1);
    check(cap_row == '0, "R9 restart row", 64'(cap_row), 0);
    for (int r = 1; r < ROWS; r++) line_and_check(r, 2, 1'b0);

    // Latch past the last row: no token left
    send_line(0, 0, N);
    do_latch(1'b0);
    check(dv == 0, "R8 line suppressed", 64'(dv), 0);
    check(sync_err == 1'b1, "R8 sync_error set", 64'(sync_err), 1);
    check(len_err == 1'b0, "R7 length still good", 64'(len_err), 0);
    line_and_check(0, 1, 1'b1);
    check(sync_err == 1'b1, "R8 sync_error sticky", 64'(sync_err), 1);

    // Short line
    apply_reset();
    check_reset_state();
    send_line(0, 3, N - 1);
    do_latch(1'b1);
    check(len_err == 1'b1, "R7 short line flagged", 64'(len_err), 1);
    check(dv == 1, "R7 short line still written", 64'(dv), 1);
    line_and_check(1, 3, 1'b0);
    check(len_err == 1'b1, "R7 length_error sticky", 64'(len_err), 1);

    // Long line
    apply_reset();
    send_line(0, 3, N + 1);
    do_latch(1'b1);
    check(len_err == 1'b1, "R7 long line flagged", 64'(len_err), 1);
    check(sync_err == 1'b0, "R8 no sync error after marker", 64'(sync_err), 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule